// File: doc/BRIEF.md
# Fractional Sawtooth Ramp Generator

This block produces a digital sawtooth ramp for one converter channel. A 16-bit accumulator in 12.4 fixed point holds the ramp position; its 12 integer bits are presented as the channel's data word. A step event moves the accumulator up or down by a programmable fractional increment. A reset event reloads the integer part with a programmable start value and zeroes the fraction.

Reset and step events each have their own trigger path. Each path is driven either by a software request pulse or by a single-cycle hardware strobe, and a per-path source select chooses which one. A software request on a path that is set to hardware is refused and reported on an error pulse. Configuration is loaded in one write cycle through a parallel port and applies to triggers from the following cycle on.

Top module: `saw_ramp_gen`

## Requirements
- R1: After reset, `ramp_data` is 0 and `req_refused` is 0. The stored configuration is then: start value 0, step 0, counting up, both sources software.
- R2: A reset trigger loads the start value into the accumulator's integer bits and clears its 4 fraction bits. A later step of 1/16 therefore moves the accumulator by exactly 1/16 from the start value.
- R3: With the direction bit at 0 (up), a step trigger adds the 16-bit step (12 integer bits above 4 fraction bits) to the accumulator.
- R4: With the direction bit at 1 (down), a step trigger subtracts the step from the accumulator.
- R5: The accumulator wraps modulo 2^16 on overflow and underflow and never saturates.
- R6: When a reset trigger and a step trigger fire in the same cycle, the reset applies and the step is discarded.
- R7: A source-select bit of 0 selects software for that path. The path's hardware strobe is then ignored.
- R8: A software request on a path whose source-select bit is 1 (hardware) does not change the ramp. It raises `req_refused` for one cycle on the following cycle.
- R9: With a source-select bit of 1, the path's hardware strobe triggers the event.
- R10: `ramp_data` equals accumulator bits [15:4]. It changes in the cycle after a trigger and holds when no trigger fires.
- R11: A configuration write takes effect for triggers in the cycle after the write, not for triggers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Load all configuration fields this cycle |
| cfg_rst_val | input | 12 | Start value loaded by a reset trigger |
| cfg_step | input | 16 | Step increment, 12.4 unsigned fixed point |
| cfg_dir_down | input | 1 | 0 = count up, 1 = count down |
| cfg_rst_src_hw | input | 1 | Reset path source: 0 software, 1 hardware |
| cfg_step_src_hw | input | 1 | Step path source: 0 software, 1 hardware |
| sw_rst_req | input | 1 | Software reset request pulse |
| sw_step_req | input | 1 | Software step request pulse |
| hw_rst_strobe | input | 1 | Hardware reset strobe, single cycle, synchronous |
| hw_step_strobe | input | 1 | Hardware step strobe, single cycle, synchronous |
| ramp_data | output | 12 | Integer part of the ramp accumulator |
| req_refused | output | 1 | One-cycle pulse after a refused software request |

## Verification
The bench builds the block with its default widths: 12 integer bits and 4 fraction bits. A 16-bit accumulator then wraps after a handful of steps from a start value near full scale. A step of all ones (4095.9375) acts as a decrement of 1/16 under wrap. A one-LSB fractional step shows whether a reset truly clears the fraction. Both source settings of each path are driven with both kinds of request, including simultaneous reset and step in both software and hardware form.

// File: rtl/saw_ramp_pkg.sv
package saw_ramp_pkg;

  localparam int unsigned RAMP_INT_W  = 12;
  localparam int unsigned RAMP_FRAC_W = 4;

  typedef enum logic {
    SRC_SW = 1'b0,
    SRC_HW = 1'b1
  } trig_src_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } ramp_dir_e;

  typedef struct packed {
    ramp_dir_e dir;
    trig_src_e rst_src;
    trig_src_e step_src;
  } ramp_mode_t;

  // index of each trigger path in the per-path arrays
  localparam int unsigned PATH_RST  = 0;
  localparam int unsigned PATH_STEP = 1;
  localparam int unsigned NUM_PATHS = 2;

endpackage

// File: rtl/saw_ramp_rst_sync.sv
module saw_ramp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/saw_ramp_cfg.sv
module saw_ramp_cfg
  import saw_ramp_pkg::*;
#(
  parameter int unsigned INT_W  = RAMP_INT_W,
  parameter int unsigned FRAC_W = RAMP_FRAC_W,
  localparam int unsigned ACC_W = INT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [INT_W-1:0] wr_rst_val,
  input  logic [ACC_W-1:0] wr_step,
  input  ramp_mode_t       wr_mode,
  output logic [INT_W-1:0] rst_val,
  output logic [ACC_W-1:0] step,
  output ramp_mode_t       mode
);

  logic [INT_W-1:0] rst_val_q, rst_val_d;
  logic [ACC_W-1:0] step_q, step_d;
  ramp_mode_t       mode_q, mode_d;

  always_comb begin
    rst_val_d = rst_val_q;
    step_d    = step_q;
    mode_d    = mode_q;
    if (wr_en) begin
      rst_val_d = wr_rst_val;
      step_d    = wr_step;
      mode_d    = wr_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_val_q <= '0;
      step_q    <= '0;
      mode_q    <= '{dir: DIR_UP, rst_src: SRC_SW, step_src: SRC_SW};
    end else begin
      rst_val_q <= rst_val_d;
      step_q    <= step_d;
      mode_q    <= mode_d;
    end
  end

  assign rst_val = rst_val_q;
  assign step    = step_q;
  assign mode    = mode_q;

endmodule

// File: rtl/saw_ramp_trig_sel.sv
module saw_ramp_trig_sel
  import saw_ramp_pkg::*;
(
  input  trig_src_e src,
  input  logic      sw_req,
  input  logic      hw_strobe,
  output logic      fire,
  output logic      refused
);

  always_comb begin
    fire    = 1'b0;
    refused = 1'b0;
    unique case (src)
      SRC_SW: fire = sw_req;
      SRC_HW: begin
        fire    = hw_strobe;
        refused = sw_req;
      end
      default: begin
        fire    = 1'b0;
        refused = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/saw_ramp_accum.sv
module saw_ramp_accum
  import saw_ramp_pkg::*;
#(
  parameter int unsigned INT_W  = RAMP_INT_W,
  parameter int unsigned FRAC_W = RAMP_FRAC_W,
  localparam int unsigned ACC_W = INT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_fire,
  input  logic             step_fire,
  input  logic [INT_W-1:0] rst_val,
  input  logic [ACC_W-1:0] step,
  input  ramp_dir_e        dir,
  output logic [ACC_W-1:0] acc
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] stepped;
  logic             acc_en;

  always_comb begin
    if (dir == DIR_DOWN) stepped = acc_q - step;
    else                 stepped = acc_q + step;
  end

  always_comb begin
    acc_en = rst_fire | step_fire;
    acc_d  = acc_q;
    if (rst_fire)       acc_d = {rst_val, {FRAC_W{1'b0}}};
    else if (step_fire) acc_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_fire && !step_fire) |=> $stable(acc_q));

  // R2
  reset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fire |=> (acc_q[ACC_W-1:FRAC_W] == $past(rst_val)) && (acc_q[FRAC_W-1:0] == '0));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !rst_fire && dir == DIR_UP) |=>
      acc_q == ACC_W'($past(acc_q) + $past(step)));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !rst_fire && dir == DIR_DOWN) |=>
      acc_q == ACC_W'($past(acc_q) - $past(step)));

endmodule

// File: rtl/saw_ramp_gen.sv
module saw_ramp_gen
  import saw_ramp_pkg::*;
#(
  parameter int unsigned INT_W  = RAMP_INT_W,
  parameter int unsigned FRAC_W = RAMP_FRAC_W,
  localparam int unsigned ACC_W = INT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [INT_W-1:0] cfg_rst_val,
  input  logic [ACC_W-1:0] cfg_step,
  input  logic             cfg_dir_down,
  input  logic             cfg_rst_src_hw,
  input  logic             cfg_step_src_hw,
  input  logic             sw_rst_req,
  input  logic             sw_step_req,
  input  logic             hw_rst_strobe,
  input  logic             hw_step_strobe,
  output logic [INT_W-1:0] ramp_data,
  output logic             req_refused
);

  logic             rst_sync_n;
  logic [INT_W-1:0] rst_val;
  logic [ACC_W-1:0] step;
  ramp_mode_t       mode;
  ramp_mode_t       wr_mode;
  logic [ACC_W-1:0] acc;

  trig_src_e            path_src    [NUM_PATHS];
  logic [NUM_PATHS-1:0] path_sw;
  logic [NUM_PATHS-1:0] path_hw;
  logic [NUM_PATHS-1:0] path_fire;
  logic [NUM_PATHS-1:0] path_refused;

  logic err_q, err_d;

  saw_ramp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_mode.dir      = cfg_dir_down    ? DIR_DOWN : DIR_UP;
    wr_mode.rst_src  = cfg_rst_src_hw  ? SRC_HW   : SRC_SW;
    wr_mode.step_src = cfg_step_src_hw ? SRC_HW   : SRC_SW;
  end

  saw_ramp_cfg #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (cfg_wr),
    .wr_rst_val (cfg_rst_val),
    .wr_step    (cfg_step),
    .wr_mode    (wr_mode),
    .rst_val    (rst_val),
    .step       (step),
    .mode       (mode)
  );

  always_comb begin
    path_src[PATH_RST]  = mode.rst_src;
    path_src[PATH_STEP] = mode.step_src;
    path_sw             = '0;
    path_hw             = '0;
    path_sw[PATH_RST]   = sw_rst_req;
    path_sw[PATH_STEP]  = sw_step_req;
    path_hw[PATH_RST]   = hw_rst_strobe;
    path_hw[PATH_STEP]  = hw_step_strobe;
  end

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    saw_ramp_trig_sel u_sel (
      .src       (path_src[p]),
      .sw_req    (path_sw[p]),
      .hw_strobe (path_hw[p]),
      .fire      (path_fire[p]),
      .refused   (path_refused[p])
    );
  end

  saw_ramp_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rst_fire  (path_fire[PATH_RST]),
    .step_fire (path_fire[PATH_STEP]),
    .rst_val   (rst_val),
    .step      (step),
    .dir       (mode.dir),
    .acc       (acc)
  );

  always_comb begin
    err_d = |path_refused;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign ramp_data   = acc[ACC_W-1:FRAC_W];
  assign req_refused = err_q;

  // R8
  refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((sw_rst_req && mode.rst_src == SRC_HW) || (sw_step_req && mode.step_src == SRC_HW))
      |=> req_refused);

  // R8
  refuse_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !((sw_rst_req && mode.rst_src == SRC_HW) || (sw_step_req && mode.step_src == SRC_HW))
      |=> !req_refused);

  // R6
  reset_priority_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (path_fire[PATH_RST] && path_fire[PATH_STEP]) |=> ramp_data == $past(rst_val));

endmodule

// File: tb/saw_ramp_gen_bench.sv
`timescale 1ns/1ps
module saw_ramp_gen_bench;

  localparam int INT_W = 12;
  localparam int ACC_W = 16;

  typedef struct packed {
    logic        we;
    logic [11:0] rv;
    logic [15:0] st;
    logic        dn;
    logic        rhw;
    logic        shw;
    logic        swr;
    logic        sws;
    logic        hwr;
    logic        hws;
    logic [11:0] eo;
    logic        ee;
  } vec_t;

  localparam int NV = 22;
  // fields: we rv st dn rhw shw | swr sws hwr hws | exp_out exp_err
  localparam logic [48:0] VEC [NV] = '{
    {1'b1,12'h100,16'h0018,1'b0,1'b0,1'b0, 4'b0000, 12'h000,1'b0}, // 0  R11 cfg, no effect yet
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b1000, 12'h100,1'b0}, // 1  R2 sw reset
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0100, 12'h101,1'b0}, // 2  R3 +1.5
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0100, 12'h103,1'b0}, // 3  R3
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0001, 12'h103,1'b0}, // 4  R7 hw step ignored
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0100, 12'h104,1'b0}, // 5  R3
    {1'b1,12'hFFF,16'h0020,1'b0,1'b1,1'b1, 4'b0000, 12'h104,1'b0}, // 6  R10 hold
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b1000, 12'h104,1'b1}, // 7  R8 refused reset
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0010, 12'hFFF,1'b0}, // 8  R9 hw reset
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0001, 12'h001,1'b0}, // 9  R5 overflow wrap
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0100, 12'h001,1'b1}, // 10 R8 refused step
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0011, 12'hFFF,1'b0}, // 11 R6 hw both
    {1'b1,12'h002,16'h0038,1'b1,1'b0,1'b0, 4'b0000, 12'hFFF,1'b0}, // 12 cfg down
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b1000, 12'h002,1'b0}, // 13 R2
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0100, 12'hFFE,1'b0}, // 14 R4 R5 underflow
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0100, 12'hFFB,1'b0}, // 15 R4
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b1100, 12'h002,1'b0}, // 16 R6 sw both
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0010, 12'h002,1'b0}, // 17 R7 hw reset ignored
    {1'b1,12'h7FF,16'hFFFF,1'b0,1'b0,1'b0, 4'b0000, 12'h002,1'b0}, // 18 cfg max step
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b1000, 12'h7FF,1'b0}, // 19 R2
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0100, 12'h7FE,1'b0}, // 20 R5 max step wraps
    {1'b0,12'h000,16'h0000,1'b0,1'b0,1'b0, 4'b0000, 12'h7FE,1'b0}  // 21 R10 hold
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_wr;
  logic [INT_W-1:0] cfg_rst_val;
  logic [ACC_W-1:0] cfg_step;
  logic             cfg_dir_down, cfg_rst_src_hw, cfg_step_src_hw;
  logic             sw_rst_req, sw_step_req, hw_rst_strobe, hw_step_strobe;
  logic [INT_W-1:0] ramp_data;
  logic             req_refused;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  saw_ramp_gen u_saw_ramp_gen (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_wr          (cfg_wr),
    .cfg_rst_val     (cfg_rst_val),
    .cfg_step        (cfg_step),
    .cfg_dir_down    (cfg_dir_down),
    .cfg_rst_src_hw  (cfg_rst_src_hw),
    .cfg_step_src_hw (cfg_step_src_hw),
    .sw_rst_req      (sw_rst_req),
    .sw_step_req     (sw_step_req),
    .hw_rst_strobe   (hw_rst_strobe),
    .hw_step_strobe  (hw_step_strobe),
    .ramp_data       (ramp_data),
    .req_refused     (req_refused)
  );

  task automatic drive(input vec_t v);
    cfg_wr          = v.we;
    cfg_rst_val     = v.rv;
    cfg_step        = v.st;
    cfg_dir_down    = v.dn;
    cfg_rst_src_hw  = v.rhw;
    cfg_step_src_hw = v.shw;
    sw_rst_req      = v.swr;
    sw_step_req     = v.sws;
    hw_rst_strobe   = v.hwr;
    hw_step_strobe  = v.hws;
  endtask

  task automatic check(input string req, input logic [11:0] eo, input logic ee);
    n_chk++;
    if (ramp_data !== eo || req_refused !== ee) begin
      n_bad++;
      $display("FAIL %s: ramp_data=%h refused=%b expected ramp_data=%h refused=%b",
               req, ramp_data, req_refused, eo, ee);
    end
  endtask

  task automatic apply(input vec_t v, input string req);
    drive(v);
    @(negedge clk);
    check(req, v.eo, v.ee);
  endtask

  function automatic vec_t mk(input logic we, input logic [11:0] rv, input logic [15:0] st,
                              input logic [3:0] trig, input logic [11:0] eo);
    vec_t v;
    v = '0;
    v.we = we; v.rv = rv; v.st = st;
    {v.swr, v.sws, v.hwr, v.hws} = trig;
    v.eo = eo;
    return v;
  endfunction

  initial begin
    drive('0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 12'h000, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 12'h000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(vec_t'(VEC[i]), $sformatf("vector %0d", i));
    end

    // R2: fraction is 0xF before this reset; a 1/16 step must not carry
    apply(mk(1'b1, 12'h7FF, 16'h0001, 4'b0000, 12'h7FE), "R11 cfg write");
    apply(mk(1'b0, 12'h000, 16'h0000, 4'b1000, 12'h7FF), "R2 reload");
    apply(mk(1'b0, 12'h000, 16'h0000, 4'b0100, 12'h7FF), "R2 fraction cleared");

    // R1: reset mid-run restores the idle state
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", 12'h000, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset configuration is step 0, software sources
    apply(mk(1'b0, 12'h000, 16'h0000, 4'b0100, 12'h000), "R1 reset cfg step");
    apply(mk(1'b0, 12'h000, 16'h0000, 4'b1000, 12'h000), "R1 reset cfg accepts sw");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule